// File: doc/BRIEF.md
# Multi-queue shared-buffer FIFO manager

This block keeps sixty-four independent hardware queues of 32-bit words inside one shared on-chip buffer. Each queue is set up by a configuration word that gives its depth, the page of the shared buffer where it starts, and two 3-bit watermark codes. Once a queue has a non-zero configuration, software or a bus master pushes a word by writing that queue's access location and pops a word by reading it. The block holds a read pointer, a write pointer and an occupancy count for every queue.

Each queue reports empty, nearly-empty, nearly-full and full. An overflow bit records a write that found its queue full. The lower thirty-two queues report all four flags as packed nibbles, plus a sticky overflow bit in a second set of packed words. The upper thirty-two queues report only a nearly-empty bitmap and a full bitmap.

The block handles one access per cycle. A read returns its data on `bus_rdata` in the cycle after the read strobe. If `bus_wr` and `bus_rd` are asserted together, the write is performed and the read is dropped.

Top module: `qm_fifo_mgr`

## Requirements
- R1: The word at address 0x40+q is queue q's configuration and reads back as written. Its fields are: bits [25:24] depth code (0, 1, 2, 3 give 16, 32, 64, 128 words); bits [21:14] base page, in units of 16 words; bits [28:26] nearly-empty code; bits [31:29] nearly-full code. After reset every configuration reads zero.
- R2: A write to address 0x00+q appends the write data to queue q. A read of 0x00+q returns the oldest entry in the next cycle and removes it. Every queue keeps first-in first-out order independently of the others, including after its pointers wrap.
- R3: A read from an empty queue returns zero and leaves the queue unchanged. A later write and read on that queue then return the written word.
- R4: A queue is full when its count equals its depth. A write to a full queue discards the data. For queues 0 to 31 that write also sets the queue's overflow bit. Queues 32 to 63 have no overflow bit, so their overflow status words stay zero.
- R5: Overflow bits are sticky. Queue q's bit is bit 2*(q%16) of the word at 0x84+q/16, and bit 2*(q%16)+1 of that word reads zero. Writing a 1 to the overflow bit clears it. Writing a 0 leaves it unchanged.
- R6: Queue q (q < 32) has a status nibble at bits [4*(q%8)+3 : 4*(q%8)] of the word at 0x80+q/8. Within the nibble, bit 0 is empty (count is 0), bit 1 is nearly-empty (count is at or below the nearly-empty threshold), bit 2 is nearly-full (free space is at or below the nearly-full threshold) and bit 3 is full. After reset these words read 0x33333333.
- R7: A 3-bit watermark code w selects the threshold: 0 when w is 0, and 2^(w-1) entries when w is 1 to 7.
- R8: For queues 32 to 63, bit q-32 of the word at 0x86 is the nearly-empty flag and bit q-32 of the word at 0x87 is the full flag. After reset these words read 0xFFFFFFFF and 0x00000000.
- R9: A queue whose configuration word is zero is unassigned. Writes to it are dropped without setting overflow, and reads of it return zero.
- R10: A write to queue q's configuration empties queue q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed location |
| bus_rd | input | 1 | Read strobe for the addressed location |
| bus_addr | input | 8 | Word address: 0x00-0x3F queue access, 0x40-0x7F configuration, 0x80-0x87 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read strobe |

## Verification
The assertions check four properties on every cycle:
- No queue's count exceeds the depth its configuration selects.
- An unassigned queue always holds nothing.
- A configuration write leaves its queue empty.
- A read of an empty queue yields zero, and overflow bits are set and cleared on the events that should set and clear them.

Only the bench's scenarios can show:
- that data comes back in order and uncorrupted through the shared buffer across interleaved queues and pointer wrap;
- that every watermark threshold falls on the right count;
- that the packed status words place each flag in the right bit.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int QM_NQ     = 64;
  localparam int QM_QW     = $clog2(QM_NQ);
  localparam int QM_LOW    = QM_NQ / 2;
  localparam int QM_AW     = QM_QW + 2;
  localparam int QM_DW     = 32;
  localparam int QM_PAGE_W = 16;
  localparam int QM_MAXD   = 128;
  localparam int QM_PTR_W  = $clog2(QM_MAXD);
  localparam int QM_CNT_W  = QM_PTR_W + 1;

  typedef struct packed {
    logic [2:0]  nf_wm;
    logic [2:0]  ne_wm;
    logic [1:0]  sz;
    logic [1:0]  rsv_hi;
    logic [7:0]  base;
    logic [13:0] rsv_lo;
  } qm_cfg_t;

  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qm_flags_t;

  function automatic logic [QM_CNT_W-1:0] qm_depth(logic [1:0] sz);
    return QM_CNT_W'(QM_PAGE_W) << sz;
  endfunction

  function automatic logic [QM_CNT_W-1:0] qm_thresh(logic [2:0] wm);
    return (wm == 3'd0) ? '0 : (QM_CNT_W'(1) << (wm - 3'd1));
  endfunction

  function automatic logic [QM_PTR_W-1:0] qm_offset(logic [1:0] sz, logic [QM_PTR_W-1:0] p);
    logic [QM_PTR_W-1:0] m;
    m = QM_PTR_W'(qm_depth(sz) - 1'b1);
    return p & m;
  endfunction

  function automatic logic qm_nempty(qm_cfg_t c, logic [QM_CNT_W-1:0] cnt);
    return cnt <= qm_thresh(c.ne_wm);
  endfunction

  function automatic logic qm_full(qm_cfg_t c, logic [QM_CNT_W-1:0] cnt);
    return cnt >= qm_depth(c.sz);
  endfunction

  function automatic qm_flags_t qm_flags(qm_cfg_t c, logic [QM_CNT_W-1:0] cnt);
    qm_flags_t f;
    f.empty  = (cnt == '0);
    f.nempty = qm_nempty(c, cnt);
    f.nfull  = (qm_depth(c.sz) - cnt) <= qm_thresh(c.nf_wm);
    f.full   = qm_full(c, cnt);
    return f;
  endfunction
endpackage

// File: rtl/qm_buffer.sv
module qm_buffer #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/qm_ptr_bank.sv
module qm_ptr_bank import qm_pkg::*; #(
  parameter int AW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                push,
  input  logic                pop,
  input  logic [QM_QW-1:0]    sel,
  input  logic [QM_DW-1:0]    cfg_wdata,
  output qm_cfg_t             cfg_o [QM_NQ],
  output logic [QM_CNT_W-1:0] cnt_o [QM_NQ],
  output logic [AW-1:0]       wr_slot,
  output logic [AW-1:0]       rd_slot
);
  qm_cfg_t             cfg_q [QM_NQ];
  logic [QM_PTR_W-1:0] wr_q  [QM_NQ];
  logic [QM_PTR_W-1:0] rd_q  [QM_NQ];
  logic [QM_CNT_W-1:0] cnt_q [QM_NQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < QM_NQ; q++) begin
        cfg_q[q] <= '0;
        wr_q[q]  <= '0;
        rd_q[q]  <= '0;
        cnt_q[q] <= '0;
      end
    end else begin
      for (int q = 0; q < QM_NQ; q++) begin
        if (sel == QM_QW'(q)) begin
          if (cfg_we) begin
            cfg_q[q] <= qm_cfg_t'(cfg_wdata);
            wr_q[q]  <= '0;
            rd_q[q]  <= '0;
            cnt_q[q] <= '0;
          end else if (push) begin
            wr_q[q]  <= wr_q[q] + 1'b1;
            cnt_q[q] <= cnt_q[q] + 1'b1;
          end else if (pop) begin
            rd_q[q]  <= rd_q[q] + 1'b1;
            cnt_q[q] <= cnt_q[q] - 1'b1;
          end
        end
      end
    end
  end

  qm_cfg_t cs;
  assign cs      = cfg_q[sel];
  assign wr_slot = AW'({cs.base, 4'b0000}) + AW'(qm_offset(cs.sz, wr_q[sel]));
  assign rd_slot = AW'({cs.base, 4'b0000}) + AW'(qm_offset(cs.sz, rd_q[sel]));
  assign cfg_o   = cfg_q;
  assign cnt_o   = cnt_q;

  for (genvar q = 0; q < QM_NQ; q++) begin : g_chk
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[q] <= qm_depth(cfg_q[q].sz));
    // R9
    idle_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[q] == '0) |-> (cnt_q[q] == '0));
    // R10
    cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sel == QM_QW'(q)) |=> (cnt_q[q] == '0));
  end
endmodule

// File: rtl/qm_status.sv
module qm_status import qm_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  qm_cfg_t             cfg_i [QM_NQ],
  input  logic [QM_CNT_W-1:0] cnt_i [QM_NQ],
  input  logic                ovf_set,
  input  logic [QM_QW-1:0]    sel,
  input  logic                clr_we,
  input  logic                clr_word,
  input  logic [15:0]         clr_bits,
  input  logic [2:0]          rsel,
  output logic [QM_DW-1:0]    word_o
);
  localparam int NIB_Q = QM_DW / 4;
  localparam int OVF_Q = QM_DW / 2;

  logic [4*QM_LOW-1:0] nib_flat;
  logic [2*QM_LOW-1:0] ovf_flat;
  logic [QM_LOW-1:0]   ne_hi;
  logic [QM_LOW-1:0]   full_hi;
  logic [QM_LOW-1:0]   ovf_q;

  for (genvar q = 0; q < QM_LOW; q++) begin : g_lo
    assign nib_flat[4*q +: 4] = qm_flags(cfg_i[q], cnt_i[q]);
    assign ovf_flat[2*q +: 2] = {1'b0, ovf_q[q]};
  end

  for (genvar h = 0; h < QM_LOW; h++) begin : g_hi
    assign ne_hi[h]   = qm_nempty(cfg_i[QM_LOW+h], cnt_i[QM_LOW+h]);
    assign full_hi[h] = qm_full(cfg_i[QM_LOW+h], cnt_i[QM_LOW+h]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
    end else begin
      for (int q = 0; q < QM_LOW; q++) begin
        if (ovf_set && sel == QM_QW'(q))
          ovf_q[q] <= 1'b1;
        else if (clr_we && clr_word == 1'((q / OVF_Q) % 2) && clr_bits[q % OVF_Q])
          ovf_q[q] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (rsel)
      3'd0, 3'd1, 3'd2, 3'd3: word_o = nib_flat[QM_DW*rsel[1:0] +: QM_DW];
      3'd4, 3'd5:             word_o = ovf_flat[QM_DW*rsel[0] +: QM_DW];
      3'd6:                   word_o = ne_hi;
      default:                word_o = full_hi;
    endcase
  end

  for (genvar q = 0; q < QM_LOW; q++) begin : g_chk
    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_set && sel == QM_QW'(q)) |=> ovf_q[q]);
    // R5
    ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_word == 1'((q / OVF_Q) % 2) && clr_bits[q % OVF_Q] && !ovf_set)
      |=> !ovf_q[q]);
  end

  initial begin
    if (NIB_Q * 4 != QM_DW) $display("qm_status: nibble packing mismatch");
  end
endmodule

// File: rtl/qm_fifo_mgr.sv
module qm_fifo_mgr import qm_pkg::*; #(
  parameter int BUF_PAGES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [QM_AW-1:0] bus_addr,
  input  logic [QM_DW-1:0] bus_wdata,
  output logic [QM_DW-1:0] bus_rdata
);
  localparam int BUF_WORDS = BUF_PAGES * QM_PAGE_W;
  localparam int BUF_AW    = $clog2(BUF_WORDS);

  logic [1:0]       region;
  logic [QM_QW-1:0] sel;
  logic [2:0]       rsel;
  logic             wr_evt, rd_evt;
  logic             acc_wr, acc_rd, cfg_we, stat_we;
  logic             sel_assigned, sel_full, push_ok, pop_ok, drop_ovf;
  logic             clr_we;
  logic [15:0]      clr_bits;

  qm_cfg_t             cfg_all [QM_NQ];
  logic [QM_CNT_W-1:0] cnt_all [QM_NQ];
  qm_cfg_t             cfg_sel;
  logic [QM_CNT_W-1:0] cnt_sel;
  logic [BUF_AW-1:0]   wr_slot, rd_slot;
  logic [QM_DW-1:0]    mem_rdata, stat_word, reg_q;
  logic                mem_sel_q;

  assign region  = bus_addr[QM_AW-1 -: 2];
  assign sel     = bus_addr[QM_QW-1:0];
  assign rsel    = bus_addr[2:0];
  assign wr_evt  = bus_wr;
  assign rd_evt  = bus_rd && !bus_wr;
  assign acc_wr  = wr_evt && (region == 2'b00);
  assign acc_rd  = rd_evt && (region == 2'b00);
  assign cfg_we  = wr_evt && (region == 2'b01);
  assign stat_we = wr_evt && region[1];

  assign cfg_sel      = cfg_all[sel];
  assign cnt_sel      = cnt_all[sel];
  assign sel_assigned = (cfg_sel != '0);
  assign sel_full     = qm_full(cfg_sel, cnt_sel);
  assign push_ok      = acc_wr && sel_assigned && !sel_full;
  assign pop_ok       = acc_rd && sel_assigned && (cnt_sel != '0);
  assign drop_ovf     = acc_wr && sel_assigned && sel_full && (int'(sel) < QM_LOW);

  assign clr_we = stat_we && (rsel[2:1] == 2'b10);
  for (genvar j = 0; j < 16; j++) begin : g_clr
    assign clr_bits[j] = bus_wdata[2*j];
  end

  qm_ptr_bank #(.AW(BUF_AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .push     (push_ok),
    .pop      (pop_ok),
    .sel      (sel),
    .cfg_wdata(bus_wdata),
    .cfg_o    (cfg_all),
    .cnt_o    (cnt_all),
    .wr_slot  (wr_slot),
    .rd_slot  (rd_slot)
  );

  qm_buffer #(.AW(BUF_AW), .DW(QM_DW)) u_buf (
    .clk  (clk),
    .we   (push_ok),
    .waddr(wr_slot),
    .wdata(bus_wdata),
    .re   (pop_ok),
    .raddr(rd_slot),
    .rdata(mem_rdata)
  );

  qm_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg_all),
    .cnt_i   (cnt_all),
    .ovf_set (drop_ovf),
    .sel     (sel),
    .clr_we  (clr_we),
    .clr_word(rsel[0]),
    .clr_bits(clr_bits),
    .rsel    (rsel),
    .word_o  (stat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_q <= 1'b0;
      reg_q     <= '0;
    end else begin
      mem_sel_q <= pop_ok;
      if (rd_evt) begin
        if (region == 2'b01)  reg_q <= QM_DW'(cfg_sel);
        else if (region[1])   reg_q <= stat_word;
        else                  reg_q <= '0;
      end
    end
  end

  assign bus_rdata = mem_sel_q ? mem_rdata : reg_q;

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && cnt_sel == '0) |=> (bus_rdata == '0));
endmodule

// File: tb/qm_fifo_mgr_test.sv
module qm_fifo_mgr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] exp_data [$];
  string       exp_tag  [$];
  logic        rd_d = 1'b0;

  logic [31:0] mcfg [64];
  logic [31:0] mq   [64][$];
  bit          movf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  qm_fifo_mgr uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int depth_of(logic [31:0] c);
    return 16 * (1 << c[25:24]);
  endfunction

  function automatic int thr_of(logic [2:0] w);
    case (w)
      3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 4;
      3'd4: return 8;  3'd5: return 16; 3'd6: return 32; default: return 64;
    endcase
  endfunction

  function automatic logic [31:0] mk(int sz, int base, int ne, int nf);
    return (32'(nf) << 29) | (32'(ne) << 26) | (32'(sz) << 24) | (32'(base) << 14);
  endfunction

  function automatic logic [3:0] nib(int q);
    int n = mq[q].size();
    int d = depth_of(mcfg[q]);
    logic [3:0] r;
    r[0] = (n == 0);
    r[1] = (n <= thr_of(mcfg[q][28:26]));
    r[2] = ((d - n) <= thr_of(mcfg[q][31:29]));
    r[3] = (n == d);
    return r;
  endfunction

  function automatic logic [31:0] exp_stat(int r);
    logic [31:0] w = '0;
    if (r < 4) begin
      for (int j = 0; j < 8; j++) w[4*j +: 4] = nib(r*8 + j);
    end else if (r < 6) begin
      for (int j = 0; j < 16; j++) w[2*j] = movf[(r-4)*16 + j];
    end else begin
      for (int j = 0; j < 32; j++) begin
        logic [3:0] f = nib(32 + j);
        w[j] = (r == 6) ? f[1] : f[3];
      end
    end
    return w;
  endfunction

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int q = int'(a[5:0]);
    if (a[7:6] == 2'b00) begin
      if (mcfg[q] != 0) begin
        if (mq[q].size() < depth_of(mcfg[q])) mq[q].push_back(d);
        else if (q < 32) movf[q] = 1;
      end
    end else if (a[7:6] == 2'b01) begin
      mcfg[q] = d;
      mq[q].delete();
    end else if (a[2:1] == 2'b10) begin
      for (int j = 0; j < 16; j++) if (d[2*j]) movf[a[0]*16 + j] = 0;
    end
  endtask

  task automatic model_read(logic [7:0] a, output logic [31:0] v);
    int q = int'(a[5:0]);
    if (a[7:6] == 2'b00) begin
      if (mcfg[q] != 0 && mq[q].size() != 0) v = mq[q].pop_front();
      else v = '0;
    end else if (a[7:6] == 2'b01) begin
      v = mcfg[q];
    end else begin
      v = exp_stat(int'(a[2:0]));
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    model_write(a, d);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    logic [31:0] v;
    @(negedge clk);
    model_read(a, v);
    exp_data.push_back(v);
    exp_tag.push_back(tag);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  // monitor: a read strobe seen at an edge yields data sampled at the following falling edge
  always @(posedge clk) rd_d <= bus_rd && !bus_wr && rst_n;

  always @(negedge clk) begin
    if (rd_d) begin
      logic [31:0] e;
      string t;
      compared++;
      if (exp_data.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard: unexpected read data %08h, expected none", bus_rdata);
      end else begin
        e = exp_data.pop_front();
        t = exp_tag.pop_front();
        if (bus_rdata !== e) begin
          mismatched++;
          $display("FAIL %s: actual %08h expected %08h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    for (int q = 0; q < 64; q++) mcfg[q] = '0;
    for (int q = 0; q < 32; q++) movf[q] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state: R6 nibbles, R8 bitmaps, R5 overflow words, R1 config
    for (int w = 0; w < 8; w++) rd(8'h80 + 8'(w), "R6 R8 R5 reset status");
    rd(8'h40, "R1 reset config");
    rd(8'h07, "R3 R9 reset access read");

    // queue 0: 16 words, page 0, nearly-empty code 2, nearly-full code 1
    wr(8'h40, mk(0, 0, 2, 1));
    rd(8'h40, "R1 config readback");
    for (int i = 0; i < 17; i++) begin
      wr(8'h00, 32'hA000 + 32'(i));
      rd(8'h80, "R6 R7 queue0 nibble");
    end
    rd(8'h84, "R4 overflow set on full write");
    for (int i = 0; i < 17; i++) rd(8'h00, "R2 R3 queue0 drain");
    wr(8'h00, 32'h0000_0055);
    rd(8'h00, "R3 pointers kept after empty read");
    wr(8'h84, 32'hFFFF_FFFE);
    rd(8'h84, "R5 zero write keeps overflow");
    wr(8'h84, 32'h0000_0001);
    rd(8'h84, "R5 one write clears overflow");

    // queues 1 and 5 interleaved, then pointer wrap on queue 1
    wr(8'h41, mk(0, 1, 3, 3));
    wr(8'h45, mk(1, 2, 1, 0));
    for (int i = 0; i < 10; i++) begin
      wr(8'h01, 32'h1100 + 32'(i));
      wr(8'h05, 32'h5500 + 32'(i));
    end
    rd(8'h80, "R6 R7 mixed nibbles");
    for (int i = 0; i < 10; i++) begin
      rd(8'h01, "R2 interleave queue1");
      rd(8'h05, "R2 interleave queue5");
    end
    for (int i = 0; i < 12; i++) wr(8'h01, 32'h1200 + 32'(i));
    rd(8'h80, "R6 wrapped occupancy");
    for (int i = 0; i < 12; i++) rd(8'h01, "R2 wrap queue1");

    // upper queue 40
    wr(8'h68, mk(0, 4, 3, 0));
    for (int i = 0; i < 18; i++) begin
      wr(8'h28, 32'h4000 + 32'(i));
      rd(8'h86, "R8 R7 upper nearly-empty map");
      rd(8'h87, "R8 upper full map");
    end
    rd(8'h84, "R4 upper full write no overflow");
    rd(8'h85, "R4 upper full write no overflow");
    for (int i = 0; i < 17; i++) rd(8'h28, "R2 upper queue drain");

    // unassigned queue 10
    wr(8'h0A, 32'h1234_5678);
    rd(8'h81, "R9 unassigned status");
    rd(8'h0A, "R9 unassigned read");
    rd(8'h84, "R9 unassigned no overflow");

    // config rewrite flushes queue 5
    for (int i = 0; i < 5; i++) wr(8'h05, 32'h5A00 + 32'(i));
    wr(8'h45, mk(1, 2, 1, 0));
    rd(8'h80, "R10 status after flush");
    rd(8'h05, "R10 flushed read");
    wr(8'h05, 32'h0000_0077);
    rd(8'h05, "R10 fresh data after flush");

    // 128-word queue 2, both codes 7 (threshold 64)
    wr(8'h42, mk(3, 8, 7, 7));
    for (int i = 0; i < 66; i++) begin
      wr(8'h02, 32'h2000 + 32'(i));
      if (i >= 61) rd(8'h80, "R7 threshold 64 boundary");
    end
    for (int i = 0; i < 66; i++) rd(8'h02, "R2 deep queue drain");
    rd(8'h80, "R6 final nibbles");

    idle(4);
    compared++;
    if (exp_data.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard R2: actual %0d pending expected 0", exp_data.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule